// File: doc/BRIEF.md
# Slotted Input Port Buffer Manager

This block is the receiving side of one input port of a four-output packet switch. Packets of a fixed number of 16-bit words arrive one word per clock when `in_valid` is high. Each packet is written into one of four single-packet slots, and the lowest-numbered free slot is taken when the header word arrives. The header carries the destination output number in its low bits. On the clock edge that takes the header, the block sends the scheduler for that output a one-cycle request that names the slot. Because the request goes out before the packet has fully arrived, the transmitter can start reading the slot while the rest of the packet is still being written.

Any slot can be read at any time through a slot/word address pair, so a packet whose output is busy never holds back packets in other slots. The last word of every packet is a check word chosen so that the XOR of all words of the packet is zero. If this check fails, the block withdraws the packet: it pulses a cancel naming the slot, frees the slot and pulses the error flag. A slot that passes the check stays busy until the transmitter returns it with a release pulse. When at most one slot remains free, `stop` tells the upstream sender to hold off, which leaves room for a packet already on the link. A header that arrives when no slot is free causes the whole packet to be discarded.

Top module: `slotbuf_port`

## Requirements
- R1: While reset is held and directly after it, all four slots are free, `stop` is low and `req_valid`, `cancel_valid` and `err` are low.
- R2: A header word (the first accepted word of a packet) taken while a slot is free occupies the lowest-numbered free slot. On the following cycle it gives a one-cycle `req_valid`, with `req_port` equal to header bits [1:0] and `req_slot` equal to that slot.
- R3: `stop` is high exactly when the number of free slots is one or zero, evaluated on the occupancy after the latest clock edge.
- R4: Word k of a packet (k = 0 for the header) is stored at word address k of its slot. `rd_data` shows the word at (`rd_slot`, `rd_addr`) one cycle after the address is applied. Words already written can be read while later words of the same packet are still arriving.
- R5: When the XOR of all 8 words of a packet that holds a slot is non-zero, the cycle after its last word shows `cancel_valid` and `err` high together for one cycle, with `cancel_slot` naming the slot. That slot is free from then on, and no `req_valid` is given in that cycle.
- R6: A `rel_valid` pulse frees the slot named by `rel_slot` from the next cycle onward. A pulse that names a free slot changes nothing.
- R7: A header that arrives with no free slot gives a one-cycle `err` on the next cycle and no request. The block discards the remaining 7 words of that packet without writing them, and slot occupancy does not change.
- R8: Slots are released in any order, independent of arrival order. A freed slot is reused by the next header according to the lowest-free rule of R2.
- R9: Cycles with `in_valid` low are ignored. Only accepted words advance the position within a packet, so a packet may arrive with gaps between its words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming word is valid this cycle |
| in_data | input | 16 | Incoming packet word |
| stop | output | 1 | Upstream sender must stop starting packets |
| req_valid | output | 1 | One-cycle request to an output scheduler |
| req_port | output | 2 | Output port the packet needs |
| req_slot | output | 2 | Slot holding the requested packet |
| cancel_valid | output | 1 | One-cycle withdrawal of a failed packet |
| cancel_slot | output | 2 | Slot of the withdrawn packet |
| err | output | 1 | One-cycle error flag (check failure or packet discarded) |
| rel_valid | input | 1 | Transmitter has finished reading a slot |
| rel_slot | input | 2 | Slot being returned |
| rd_slot | input | 2 | Read slot select |
| rd_addr | input | 3 | Read word address within the slot |
| rd_data | output | 16 | Read word, one cycle after the address |

## Verification
Every result comes from a single register stage. The request or drop error for a header is due on the cycle after the header's clock edge, and the cancel and error for a bad check word are due on the cycle after the last word. Occupancy, and with it `stop`, reflects a release or allocation right after that edge, and read data lags its address by one edge. The bench drives all inputs at the falling edge, lets one rising edge pass, then compares every output at the next falling edge against a step-by-step model that is updated with the same inputs. This keeps each comparison aligned to the exact cycle its result is due. Read data is compared only for locations the model knows to be written.

// File: rtl/slotbuf_pkg.sv
package slotbuf_pkg;
   typedef enum logic [1:0] {
      RX_HDR  = 2'd0,
      RX_BODY = 2'd1,
      RX_SKIP = 2'd2
   } rx_mode_e;
endpackage

// File: rtl/slotbuf_alloc.sv
// Slot occupancy, lowest-free selection and the upstream stop signal.
module slotbuf_alloc #(
   parameter int NSLOT     = 4,
   parameter int STOP_FREE = 1,
   localparam int SLOT_W   = $clog2(NSLOT),
   localparam int CNT_W    = $clog2(NSLOT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_req,
   input  logic              drop_valid,
   input  logic [SLOT_W-1:0] drop_slot,
   input  logic              rel_valid,
   input  logic [SLOT_W-1:0] rel_slot,
   output logic              grant_ok,
   output logic [SLOT_W-1:0] grant_slot,
   output logic [NSLOT-1:0]  busy,
   output logic              stop
);
   logic [NSLOT-1:0] busy_q;
   logic [CNT_W-1:0] free_cnt;

   always_comb begin
      grant_ok   = 1'b0;
      grant_slot = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (!busy_q[i]) begin
            grant_ok   = 1'b1;
            grant_slot = SLOT_W'(i);
         end
      end
   end

   always_comb begin
      free_cnt = '0;
      for (int i = 0; i < NSLOT; i++) begin
         free_cnt = free_cnt + CNT_W'(!busy_q[i]);
      end
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic set_s, clr_s;
      assign set_s = alloc_req && grant_ok && (grant_slot == SLOT_W'(s));
      assign clr_s = (rel_valid && (rel_slot == SLOT_W'(s))) ||
                     (drop_valid && (drop_slot == SLOT_W'(s)));
      always_ff @(posedge clk) begin
         if (!rst_n)     busy_q[s] <= 1'b0;
         else if (set_s) busy_q[s] <= 1'b1;
         else if (clr_s) busy_q[s] <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign stop = (int'(free_cnt) <= STOP_FREE);
endmodule

// File: rtl/slotbuf_rx.sv
// Packet framing, destination decode, check-word test and scheduler request.
module slotbuf_rx
   import slotbuf_pkg::*;
#(
   parameter int DW        = 16,
   parameter int PKT_WORDS = 8,
   parameter int NSLOT     = 4,
   parameter int NPORT     = 4,
   parameter int DEST_LSB  = 0,
   localparam int SLOT_W   = $clog2(NSLOT),
   localparam int PORT_W   = $clog2(NPORT),
   localparam int ADDR_W   = $clog2(PKT_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DW-1:0]     in_data,
   input  logic              grant_ok,
   input  logic [SLOT_W-1:0] grant_slot,
   output logic              alloc_req,
   output logic              fail_now,
   output logic [SLOT_W-1:0] fail_slot,
   output logic              wr_en,
   output logic [SLOT_W-1:0] wr_slot,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DW-1:0]     wr_data,
   output logic              req_valid,
   output logic [PORT_W-1:0] req_port,
   output logic [SLOT_W-1:0] req_slot,
   output logic              cancel_valid,
   output logic [SLOT_W-1:0] cancel_slot,
   output logic              err
);
   localparam logic [ADDR_W-1:0] LAST = ADDR_W'(PKT_WORDS - 1);

   rx_mode_e          mode_q;
   logic [ADDR_W-1:0] cnt_q;
   logic [SLOT_W-1:0] slot_q;
   logic [DW-1:0]     acc_q;
   logic              is_last;
   logic              drop_hdr;

   assign is_last   = (cnt_q == LAST);
   assign alloc_req = in_valid && (mode_q == RX_HDR);
   assign drop_hdr  = alloc_req && !grant_ok;
   assign fail_now  = in_valid && (mode_q == RX_BODY) && is_last &&
                      ((acc_q ^ in_data) != '0);
   assign fail_slot = slot_q;

   assign wr_en   = in_valid && (((mode_q == RX_HDR) && grant_ok) || (mode_q == RX_BODY));
   assign wr_slot = (mode_q == RX_HDR) ? grant_slot : slot_q;
   assign wr_addr = cnt_q;
   assign wr_data = in_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= RX_HDR;
         cnt_q  <= '0;
         slot_q <= '0;
         acc_q  <= '0;
      end else if (in_valid) begin
         unique case (mode_q)
            RX_HDR: begin
               cnt_q  <= ADDR_W'(1);
               acc_q  <= in_data;
               slot_q <= grant_slot;
               mode_q <= grant_ok ? RX_BODY : RX_SKIP;
            end
            RX_BODY, RX_SKIP: begin
               if (is_last) begin
                  cnt_q  <= '0;
                  mode_q <= RX_HDR;
               end else begin
                  cnt_q <= cnt_q + ADDR_W'(1);
                  acc_q <= acc_q ^ in_data;
               end
            end
            default: mode_q <= RX_HDR;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_valid    <= 1'b0;
         req_port     <= '0;
         req_slot     <= '0;
         cancel_valid <= 1'b0;
         cancel_slot  <= '0;
         err          <= 1'b0;
      end else begin
         req_valid    <= alloc_req && grant_ok;
         cancel_valid <= fail_now;
         err          <= fail_now || drop_hdr;
         if (alloc_req && grant_ok) begin
            req_port <= in_data[DEST_LSB +: PORT_W];
            req_slot <= grant_slot;
         end
         if (fail_now) cancel_slot <= slot_q;
      end
   end
endmodule

// File: rtl/slotbuf_store.sv
// Per-slot word storage with independent read selection.
module slotbuf_store #(
   parameter int DW        = 16,
   parameter int PKT_WORDS = 8,
   parameter int NSLOT     = 4,
   parameter bit REG_READ  = 1'b1,
   localparam int SLOT_W   = $clog2(NSLOT),
   localparam int ADDR_W   = $clog2(PKT_WORDS)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data
);
   logic [DW-1:0] rd_word [NSLOT];

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [DW-1:0] words [PKT_WORDS];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == SLOT_W'(s))) words[wr_addr] <= wr_data;
      end
      assign rd_word[s] = words[rd_addr];
   end

   if (REG_READ) begin : g_reg_rd
      always_ff @(posedge clk) rd_data <= rd_word[rd_slot];
   end else begin : g_comb_rd
      assign rd_data = rd_word[rd_slot];
   end
endmodule

// File: rtl/slotbuf_port.sv
module slotbuf_port #(
   parameter int DW        = 16,
   parameter int PKT_WORDS = 8,
   parameter int NSLOT     = 4,
   parameter int NPORT     = 4,
   parameter int DEST_LSB  = 0,
   parameter int STOP_FREE = 1,
   parameter bit REG_READ  = 1'b1,
   localparam int SLOT_W   = $clog2(NSLOT),
   localparam int PORT_W   = $clog2(NPORT),
   localparam int ADDR_W   = $clog2(PKT_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DW-1:0]     in_data,
   output logic              stop,
   output logic              req_valid,
   output logic [PORT_W-1:0] req_port,
   output logic [SLOT_W-1:0] req_slot,
   output logic              cancel_valid,
   output logic [SLOT_W-1:0] cancel_slot,
   output logic              err,
   input  logic              rel_valid,
   input  logic [SLOT_W-1:0] rel_slot,
   input  logic [SLOT_W-1:0] rd_slot,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DW-1:0]     rd_data
);
   if (PKT_WORDS < 2)               begin : g_bad_len  $error("PKT_WORDS must be at least 2");          end
   if (NSLOT < 2)                   begin : g_bad_slot $error("NSLOT must be at least 2");              end
   if ((1 << SLOT_W) != NSLOT)      begin : g_pow_slot $error("NSLOT must be a power of two");          end
   if ((1 << ADDR_W) != PKT_WORDS)  begin : g_pow_len  $error("PKT_WORDS must be a power of two");      end
   if (DEST_LSB + PORT_W > DW)      begin : g_bad_dest $error("destination field exceeds word width");  end
   if (STOP_FREE >= NSLOT)          begin : g_bad_stop $error("STOP_FREE must be below NSLOT");         end

   logic              grant_ok, alloc_req, fail_now, wr_en;
   logic [SLOT_W-1:0] grant_slot, fail_slot, wr_slot;
   logic [ADDR_W-1:0] wr_addr;
   logic [DW-1:0]     wr_data;
   logic [NSLOT-1:0]  busy;

   slotbuf_alloc #(.NSLOT(NSLOT), .STOP_FREE(STOP_FREE)) u_alloc (
      .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req),
      .drop_valid(fail_now), .drop_slot(fail_slot),
      .rel_valid(rel_valid), .rel_slot(rel_slot),
      .grant_ok(grant_ok), .grant_slot(grant_slot),
      .busy(busy), .stop(stop)
   );

   slotbuf_rx #(.DW(DW), .PKT_WORDS(PKT_WORDS), .NSLOT(NSLOT), .NPORT(NPORT),
                .DEST_LSB(DEST_LSB)) u_rx (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .grant_ok(grant_ok), .grant_slot(grant_slot), .alloc_req(alloc_req),
      .fail_now(fail_now), .fail_slot(fail_slot),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr), .wr_data(wr_data),
      .req_valid(req_valid), .req_port(req_port), .req_slot(req_slot),
      .cancel_valid(cancel_valid), .cancel_slot(cancel_slot), .err(err)
   );

   slotbuf_store #(.DW(DW), .PKT_WORDS(PKT_WORDS), .NSLOT(NSLOT),
                   .REG_READ(REG_READ)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_slot(wr_slot), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: rtl/slotbuf_port_chk.sv
module slotbuf_port_chk #(
   parameter int NSLOT     = 4,
   localparam int SLOT_W   = $clog2(NSLOT)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NSLOT-1:0]  busy,
   input logic              stop,
   input logic              req_valid,
   input logic [SLOT_W-1:0] req_slot,
   input logic              cancel_valid,
   input logic [SLOT_W-1:0] cancel_slot,
   input logic              err,
   input logic              rel_valid,
   input logic [SLOT_W-1:0] rel_slot
);
   AST_REQ_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> busy[req_slot]);  // R2
   AST_FULL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (&busy) |-> stop);  // R3
   AST_ONE_FREE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(busy) == NSLOT - 1) |-> stop);  // R3
   AST_CANCEL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_valid |-> !busy[cancel_slot]);  // R5
   AST_CANCEL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      cancel_valid |-> (err && !req_valid));  // R5
   AST_RELEASE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && busy[rel_slot]) |=> !busy[$past(rel_slot)]);  // R6
   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_valid, cancel_valid}));  // R2
endmodule

bind slotbuf_port slotbuf_port_chk #(.NSLOT(NSLOT)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .stop(stop),
   .req_valid(req_valid), .req_slot(req_slot),
   .cancel_valid(cancel_valid), .cancel_slot(cancel_slot), .err(err),
   .rel_valid(rel_valid), .rel_slot(rel_slot)
);

// File: tb/tb_slotbuf_port.sv
module tb_slotbuf_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        stop, req_valid, cancel_valid, err;
   logic [1:0]  req_port, req_slot, cancel_slot;
   logic        rel_valid = 1'b0;
   logic [1:0]  rel_slot = '0;
   logic [1:0]  rd_slot = '0;
   logic [2:0]  rd_addr = '0;
   logic [15:0] rd_data;

   always #4 clk = ~clk;

   slotbuf_port dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .stop(stop), .req_valid(req_valid), .req_port(req_port), .req_slot(req_slot),
      .cancel_valid(cancel_valid), .cancel_slot(cancel_slot), .err(err),
      .rel_valid(rel_valid), .rel_slot(rel_slot),
      .rd_slot(rd_slot), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   bit [3:0]    mb = '0;
   int          m_mode = 0;   // 0 header, 1 body, 2 discard
   int          m_cnt = 0;
   int          m_slot = 0;
   logic [15:0] m_acc = '0;
   logic [15:0] mm [4][8];
   bit          mw [4][8];
   logic [15:0] pw [8];

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   function automatic int nfree(input bit [3:0] b);
      int n = 0;
      for (int i = 0; i < 4; i++) if (!b[i]) n++;
      return n;
   endfunction

   function automatic bit done_slot(input int s);
      return mb[s] && !(m_mode == 1 && m_slot == s);
   endfunction

   // one clock: drive at falling edge, model, compare at next falling edge
   task automatic step(input bit v, input logic [15:0] d, input bit rv,
                       input int rs, input int qs, input int qa);
      bit e_req = 0, e_can = 0, e_err = 0, e_rok;
      int e_port = 0, e_slot = 0, e_cslot = 0, f = -1;
      logic [15:0] e_rd;
      bit [3:0] nb;
      in_valid = v; in_data = d; rel_valid = rv; rel_slot = 2'(rs);
      rd_slot = 2'(qs); rd_addr = 3'(qa);
      e_rok = mw[qs][qa]; e_rd = mm[qs][qa];
      nb = mb;
      if (rv) nb[rs] = 1'b0;
      if (v) begin
         if (m_mode == 0) begin
            for (int i = 3; i >= 0; i--) if (!mb[i]) f = i;
            if (f >= 0) begin
               e_req = 1; e_port = int'(d[1:0]); e_slot = f;
               m_slot = f; mm[f][0] = d; mw[f][0] = 1; m_acc = d;
               m_mode = 1; m_cnt = 1;
            end else begin
               e_err = 1; m_mode = 2; m_cnt = 1;
            end
         end else begin
            if (m_mode == 1) begin mm[m_slot][m_cnt] = d; mw[m_slot][m_cnt] = 1; end
            if (m_cnt == 7) begin
               if (m_mode == 1 && (m_acc ^ d) != 16'h0) begin
                  e_can = 1; e_err = 1; e_cslot = m_slot; nb[m_slot] = 1'b0;
               end
               m_mode = 0; m_cnt = 0;
            end else begin
               m_cnt++; m_acc = m_acc ^ d;
            end
         end
      end
      if (f >= 0) nb[f] = 1'b1;
      mb = nb;
      @(posedge clk);
      @(negedge clk);
      chk("R2 req_valid", 16'(req_valid), 16'(e_req));
      if (e_req) begin
         chk("R2 req_port", 16'(req_port), 16'(e_port));
         chk("R2/R8 req_slot", 16'(req_slot), 16'(e_slot));
      end
      chk("R5 cancel_valid", 16'(cancel_valid), 16'(e_can));
      if (e_can) chk("R5 cancel_slot", 16'(cancel_slot), 16'(e_cslot));
      chk("R5/R7 err", 16'(err), 16'(e_err));
      chk("R3/R6 stop", 16'(stop), 16'(nfree(mb) <= 1));
      if (e_rok) chk("R4 rd_data", rd_data, e_rd);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, '0, 0, 0, $urandom_range(0, 3), $urandom_range(0, 7));
   endtask

   task automatic make_pkt(input int dest, input bit bad);
      logic [15:0] x = '0;
      for (int i = 0; i < 7; i++) begin
         pw[i] = 16'($urandom);
         if (i == 0) pw[0][1:0] = 2'(dest);
         x = x ^ pw[i];
      end
      pw[7] = bad ? (x ^ 16'h0040) : x;
   endtask

   // sends a packet; gap > 0 inserts idle cycles (R9)
   task automatic send_pkt(input int dest, input bit bad, input int gap);
      make_pkt(dest, bad);
      for (int i = 0; i < 8; i++) begin
         step(1, pw[i], 0, 0, $urandom_range(0, 3), $urandom_range(0, 7));
         if (gap > 0 && i < 7) idle(gap);
      end
   endtask

   task automatic release_slot(input int s);
      step(0, '0, 1, s, 0, 0);
   endtask

   initial begin
      void'($urandom(32'h5107_B0FF));
      for (int s = 0; s < 4; s++) for (int a = 0; a < 8; a++) begin mw[s][a] = 0; mm[s][a] = '0; end
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk("R1 stop in reset", 16'(stop), 16'h0);
      chk("R1 req in reset", 16'(req_valid), 16'h0);
      chk("R1 err in reset", 16'(err), 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 cancel after reset", 16'(cancel_valid), 16'h0);
      chk("R1 stop after reset", 16'(stop), 16'h0);

      // R2, R4: good packet to slot 0, streaming reads while it arrives
      make_pkt(2, 0);
      for (int i = 0; i < 8; i++) step(1, pw[i], 0, 0, 0, (i == 0) ? 0 : i - 1);
      step(0, '0, 0, 0, 0, 7);
      // R5: bad check word, occupies slot 1 then withdrawn
      send_pkt(1, 1, 0);
      // R8: freed slot 1 reused; R9 with gaps
      send_pkt(3, 0, 2);
      // R3: third occupied slot leaves one free -> stop
      send_pkt(0, 0, 0);
      send_pkt(1, 0, 1);
      // R7: all slots busy -> discarded
      send_pkt(2, 0, 0);
      idle(2);
      // R6, R8: out-of-order release, reuse
      release_slot(2);
      release_slot(2);   // R6 release of a free slot: no change
      send_pkt(3, 0, 0);
      release_slot(0);
      release_slot(3);
      release_slot(1);
      idle(2);

      // constrained random phase
      for (int n = 0; n < 400; n++) begin
         int dest = $urandom_range(0, 3);
         bit bad = ($urandom_range(0, 5) == 0);
         make_pkt(dest, bad);
         for (int i = 0; i < 8; i++) begin
            int rs = $urandom_range(0, 3);
            bit rv = ($urandom_range(0, 3) == 0) && done_slot(rs);
            while ($urandom_range(0, 3) == 0) begin
               step(0, '0, rv, rs, $urandom_range(0, 3), $urandom_range(0, 7));
               rv = 0;
            end
            step(1, pw[i], rv && done_slot(rs), rs, $urandom_range(0, 3), $urandom_range(0, 7));
         end
      end
      idle(3);
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule